// File: doc/BRIEF.md
# Pulsed-Index Segment Encoder

This unit applies segment-level encoding to a 16-bit data word held in an internal word register. The word is viewed as a row of equal segments of 4, 8 or 16 bits. A held configuration picks the segment size and which segment is worked on. A started operation then does one of two things to that segment. It may complement it or mirror its bit order, either unconditionally or only when doing so helps. It may also do both. The encoded segment goes back in place, and the unit reports the new set-bit count and a two-bit record of what was applied.

The same unit packs two 2-bit encoding records into a 4-bit header record, and unpacks a header record into two. A surrounding sequencer loads the word and sets the configuration. It then issues one operation per strobe and reads the results one cycle later, in order to keep the number of transmitted pulses low.

Top module: `seg_encoder`

## Requirements
- R1: After reset, word_o, cnt_o, flags_o, hdr_o, split_a_o, split_b_o and done_o are all zero, and the held size code and segment number are both 0.
- R2: load_i writes load_data_i into word_o at the next edge. When load_i and start_i are high together, the load wins, the operation is dropped and done_o stays low.
- R3: Size code 0, 1 or 2 selects a segment of 4, 8 or 16 bits. Segment n occupies word bits [n*size +: size]. Size and segment number are captured only when cfg_we_i is high, and the captured values stay in use until the next write.
- R4: If the selected segment would reach past bit 15, or the size code is 3, an encode operation leaves word_o unchanged and reports cnt_o = 0 and flags_o = 0.
- R5: Op 0 complements the segment, sets flags_o = 2'b01 and sets cnt_o = size minus the original set-bit count. Flag bit 0 means complemented and flag bit 1 means mirrored.
- R6: Op 1 complements the segment only when its set-bit count is strictly greater than half the size, giving flags_o = 2'b01. Otherwise the data is unchanged, flags_o = 2'b00 and cnt_o is the segment's set-bit count.
- R7: Op 2 mirrors the segment's bit order, sets flags_o = 2'b10 and reports the unchanged set-bit count.
- R8: Op 3 mirrors the segment only when its unsigned value is strictly greater than the mirrored value, giving flags_o = 2'b10. Otherwise it leaves the data as it is with flags_o = 2'b00.
- R9: Op 4 complements the segment and then mirrors it, sets flags_o = 2'b11 and sets cnt_o = size minus the original set-bit count.
- R10: An encode operation changes only the bits of the selected segment. All other bits of word_o are kept.
- R11: Op 5 sets hdr_o = {opa_i[1:0], opb_i[1:0]} and leaves word_o, cnt_o and flags_o unchanged.
- R12: Op 6 sets split_b_o = opa_i[1:0] and split_a_o = opa_i[3:2]. Op 7 changes no output other than done_o.
- R13: done_o is high for exactly the one cycle after an accepted start. With neither start nor load, word_o holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write load_data_i into the word register |
| load_data_i | input | 16 | Word to load |
| cfg_we_i | input | 1 | Capture size_i and sel_i |
| size_i | input | 2 | Segment size code (0:4, 1:8, 2:16 bits) |
| sel_i | input | 2 | Segment number |
| start_i | input | 1 | Start one operation |
| op_i | input | 3 | Operation code 0..7 |
| opa_i | input | 4 | Flag operand A (combine) or header (split) |
| opb_i | input | 2 | Flag operand B (combine) |
| word_o | output | 16 | Word register |
| cnt_o | output | 5 | Set-bit count of the encoded segment |
| flags_o | output | 2 | Encoding record of the last encode |
| hdr_o | output | 4 | Combined header record |
| split_a_o | output | 2 | Upper pair from split |
| split_b_o | output | 2 | Lower pair from split |
| done_o | output | 1 | Operation completed |

## Verification
On every cycle the assertions check the following. The strobe-to-done timing and load priority hold. A conditional complement never reports a mirror and a conditional mirror never reports a complement. A mirror keeps the word's set-bit count. Flag-pack operations leave the word and encode results untouched. The exact encoded values, the strict threshold edges (half-full segments, palindromic segments), the out-of-range positions and the holding of the configuration can only be shown by the bench's scenarios, which compare against hand-derived results.

// File: rtl/seg_enc_pkg.sv
package seg_enc_pkg;
  localparam int DATA_W    = 16;
  localparam int MIN_SEG_W = 4;
  localparam int NUM_SIZES = 3;
  localparam int SEL_W     = 2;
  localparam int SIZE_W    = 2;
  localparam int FLAG_W    = 2;
  localparam int HDR_W     = 2 * FLAG_W;
  localparam int CNT_W     = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    OP_INV    = 3'd0,
    OP_INVC   = 3'd1,
    OP_REV    = 3'd2,
    OP_REVC   = 3'd3,
    OP_INVREV = 3'd4,
    OP_COMB   = 3'd5,
    OP_SPLIT  = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;
endpackage

// File: rtl/seg_lane.sv
module seg_lane
  import seg_enc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SW    = 4,
  parameter int SL_W  = 2,
  parameter int CW    = 5
) (
  input  logic [DW-1:0]   word_i,
  input  logic [SL_W-1:0] sel_i,
  input  op_e             op_i,
  output logic [DW-1:0]   word_o,
  output logic [CW-1:0]   cnt_o,
  output logic [1:0]      flags_o
);
  localparam int NSEG = DW / SW;
  localparam int HALF = SW / 2;

  function automatic logic [SW-1:0] mirror(input logic [SW-1:0] v);
    logic [SW-1:0] r;
    for (int i = 0; i < SW; i++) r[i] = v[SW-1-i];
    return r;
  endfunction

  logic [SW-1:0] seg, seg_mir, stage, enc;
  logic          hit, do_inv, do_rev;
  logic [CW-1:0] pop;

  always_comb begin
    seg = '0;
    hit = 1'b0;
    for (int p = 0; p < NSEG; p++) begin
      if (int'(sel_i) == p) begin
        seg = word_i[p*SW +: SW];
        hit = 1'b1;
      end
    end
  end

  assign seg_mir = mirror(seg);
  assign pop     = CW'($countones(seg));

  always_comb begin
    do_inv = 1'b0;
    do_rev = 1'b0;
    unique case (op_i)
      OP_INV:    do_inv = 1'b1;
      OP_INVC:   do_inv = (int'(pop) > HALF);
      OP_REV:    do_rev = 1'b1;
      OP_REVC:   do_rev = (seg > seg_mir);
      OP_INVREV: begin do_inv = 1'b1; do_rev = 1'b1; end
      default:   ;
    endcase
  end

  // complement first, then mirror
  assign stage = do_inv ? ~seg : seg;
  assign enc   = do_rev ? mirror(stage) : stage;

  always_comb begin
    word_o = word_i;
    for (int p = 0; p < NSEG; p++) begin
      if (hit && int'(sel_i) == p) word_o[p*SW +: SW] = enc;
    end
  end

  assign cnt_o   = !hit ? '0 : (do_inv ? CW'(SW) - pop : pop);
  assign flags_o = hit ? {do_rev, do_inv} : 2'b00;
endmodule

// File: rtl/seg_flag_unit.sv
module seg_flag_unit
  import seg_enc_pkg::*;
(
  input  logic [HDR_W-1:0]  opa_i,
  input  logic [FLAG_W-1:0] opb_i,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [FLAG_W-1:0] split_a_o,
  output logic [FLAG_W-1:0] split_b_o
);
  assign hdr_o     = {opa_i[FLAG_W-1:0], opb_i};
  assign split_a_o = opa_i[HDR_W-1:FLAG_W];
  assign split_b_o = opa_i[FLAG_W-1:0];
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
  import seg_enc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              cfg_we_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [HDR_W-1:0]  opa_i,
  input  logic [FLAG_W-1:0] opb_i,
  output logic [DATA_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [FLAG_W-1:0] split_a_o,
  output logic [FLAG_W-1:0] split_b_o,
  output logic              done_o
);
  op_e op;
  assign op = op_e'(op_i);

  logic [SIZE_W-1:0] size_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FLAG_W-1:0] flags_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [FLAG_W-1:0] spa_q, spb_q;
  logic              done_q;

  logic [DATA_W-1:0] lane_word  [NUM_SIZES];
  logic [CNT_W-1:0]  lane_cnt   [NUM_SIZES];
  logic [FLAG_W-1:0] lane_flags [NUM_SIZES];

  // one lane per supported segment width
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
    seg_lane #(
      .DW   (DATA_W),
      .SW   (MIN_SEG_W << k),
      .SL_W (SEL_W),
      .CW   (CNT_W)
    ) u_lane (
      .word_i  (word_q),
      .sel_i   (sel_q),
      .op_i    (op),
      .word_o  (lane_word[k]),
      .cnt_o   (lane_cnt[k]),
      .flags_o (lane_flags[k])
    );
  end

  logic [DATA_W-1:0] enc_word;
  logic [CNT_W-1:0]  enc_cnt;
  logic [FLAG_W-1:0] enc_flags;

  always_comb begin
    enc_word  = word_q;
    enc_cnt   = '0;
    enc_flags = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (int'(size_q) == k) begin
        enc_word  = lane_word[k];
        enc_cnt   = lane_cnt[k];
        enc_flags = lane_flags[k];
      end
    end
  end

  logic [HDR_W-1:0]  fu_hdr;
  logic [FLAG_W-1:0] fu_spa, fu_spb;

  seg_flag_unit u_flags (
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .hdr_o     (fu_hdr),
    .split_a_o (fu_spa),
    .split_b_o (fu_spb)
  );

  logic is_enc;
  assign is_enc = (op_i <= 3'(OP_INVREV));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q  <= '0;
      sel_q   <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      flags_q <= '0;
      hdr_q   <= '0;
      spa_q   <= '0;
      spb_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we_i) begin
        size_q <= size_i;
        sel_q  <= sel_i;
      end
      if (load_i) begin
        word_q <= load_data_i;
      end else if (start_i) begin
        done_q <= 1'b1;
        if (is_enc) begin
          word_q  <= enc_word;
          cnt_q   <= enc_cnt;
          flags_q <= enc_flags;
        end else if (op == OP_COMB) begin
          hdr_q <= fu_hdr;
        end else if (op == OP_SPLIT) begin
          spa_q <= fu_spa;
          spb_q <= fu_spb;
        end
      end
    end
  end

  assign word_o    = word_q;
  assign cnt_o     = cnt_q;
  assign flags_o   = flags_q;
  assign hdr_o     = hdr_q;
  assign split_a_o = spa_q;
  assign split_b_o = spb_q;
  assign done_o    = done_q;
endmodule

// File: rtl/seg_encoder_chk.sv
module seg_encoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        load_i,
  input logic [15:0] load_data_i,
  input logic        start_i,
  input logic [2:0]  op_i,
  input logic [3:0]  opa_i,
  input logic [1:0]  opb_i,
  input logic [15:0] word_o,
  input logic [4:0]  cnt_o,
  input logic [1:0]  flags_o,
  input logic [3:0]  hdr_o,
  input logic [1:0]  split_a_o,
  input logic [1:0]  split_b_o,
  input logic        done_o
);
  logic acc;
  assign acc = start_i && !load_i;

  assert_done_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> done_o);
  assert_no_done_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !done_o);
  assert_idle_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !load_i) |=> $stable(word_o));
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (word_o == $past(load_data_i)));
  assert_invc_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i == 3'd1) |=> !flags_o[1]);
  assert_revc_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i == 3'd3) |=> !flags_o[0]);
  assert_mirror_pop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (op_i == 3'd2 || op_i == 3'd3)) |=>
      ($countones(word_o) == $countones($past(word_o))));
  assert_flagop_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i >= 3'd5) |=> ($stable(word_o) && $stable(cnt_o) && $stable(flags_o)));
  assert_comb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i == 3'd5) |=> (hdr_o == {$past(opa_i[1:0]), $past(opb_i)}));
  assert_split_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i == 3'd6) |=> (split_a_o == $past(opa_i[3:2]) && split_b_o == $past(opa_i[1:0])));
endmodule

bind seg_encoder seg_encoder_chk u_chk (.*);

// File: tb/seg_encoder_bench.sv
module seg_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] load_data_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [1:0]  sel_i = '0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [3:0]  opa_i = '0;
  logic [1:0]  opb_i = '0;
  logic [15:0] word_o;
  logic [4:0]  cnt_o;
  logic [1:0]  flags_o;
  logic [3:0]  hdr_o;
  logic [1:0]  split_a_o;
  logic [1:0]  split_b_o;
  logic        done_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seg_encoder u_seg_encoder (.*);

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [15:0] w;
    logic [1:0]  sz;
    logic [1:0]  sl;
    logic [2:0]  op;
    logic [15:0] ew;
    logic [4:0]  ec;
    logic [1:0]  ef;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 2'd0, 2'd1, 3'd0, 16'h12C4, 5'd2,  2'b01, 4'd5},  // R5
    '{16'h00F0, 2'd0, 2'd1, 3'd1, 16'h0000, 5'd0,  2'b01, 4'd6},  // R6 full
    '{16'h0070, 2'd0, 2'd1, 3'd1, 16'h0080, 5'd1,  2'b01, 4'd6},  // R6 3 of 4
    '{16'h0030, 2'd0, 2'd1, 3'd1, 16'h0030, 5'd2,  2'b00, 4'd6},  // R6 exactly half
    '{16'hABCD, 2'd1, 2'd1, 3'd2, 16'hD5CD, 5'd5,  2'b10, 4'd7},  // R7
    '{16'h0080, 2'd1, 2'd0, 3'd3, 16'h0001, 5'd1,  2'b10, 4'd8},  // R8 applies
    '{16'h0001, 2'd1, 2'd0, 3'd3, 16'h0001, 5'd1,  2'b00, 4'd8},  // R8 smaller
    '{16'h8001, 2'd2, 2'd0, 3'd3, 16'h8001, 5'd2,  2'b00, 4'd8},  // R8 palindrome
    '{16'h00F0, 2'd2, 2'd0, 3'd4, 16'hF0FF, 5'd12, 2'b11, 4'd9},  // R9
    '{16'h1E00, 2'd0, 2'd3, 3'd4, 16'h7E00, 5'd3,  2'b11, 4'd10}, // R10 top nibble
    '{16'h5A5A, 2'd1, 2'd2, 3'd0, 16'h5A5A, 5'd0,  2'b00, 4'd4},  // R4 past bit 15
    '{16'h5A5A, 2'd2, 2'd1, 3'd0, 16'h5A5A, 5'd0,  2'b00, 4'd4},  // R4
    '{16'h5A5A, 2'd3, 2'd0, 3'd0, 16'h5A5A, 5'd0,  2'b00, 4'd4},  // R4 size code 3
    '{16'hFFFF, 2'd2, 2'd0, 3'd1, 16'h0000, 5'd0,  2'b01, 4'd3},  // R3 16-bit lane
    '{16'h0F00, 2'd1, 2'd1, 3'd1, 16'h0F00, 5'd4,  2'b00, 4'd3}   // R3 8-bit lane, half
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    #(3*CLK_PERIOD + 2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 word", word_o, 0);
    check("R1 cnt", cnt_o, 0);
    check("R1 flags", flags_o, 0);
    check("R1 hdr", hdr_o, 0);
    check("R1 split", {split_a_o, split_b_o}, 0);
    check("R1 done", done_o, 0);
    // R1 held config is size 0 seg 0: invert bottom nibble
    start_i = 1'b1; op_i = 3'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R1 cfg word", word_o, 16'h000F);

    for (int i = 0; i < NV; i++) begin
      load_i = 1'b1; load_data_i = VECS[i].w;
      cfg_we_i = 1'b1; size_i = VECS[i].sz; sel_i = VECS[i].sl;
      @(negedge clk_i);
      load_i = 1'b0; cfg_we_i = 1'b0;
      start_i = 1'b1; op_i = VECS[i].op;
      @(negedge clk_i);
      start_i = 1'b0;
      check($sformatf("R%0d vec%0d word", VECS[i].rq, i), word_o, VECS[i].ew);
      check($sformatf("R%0d vec%0d cnt", VECS[i].rq, i), cnt_o, VECS[i].ec);
      check($sformatf("R%0d vec%0d flags", VECS[i].rq, i), flags_o, VECS[i].ef);
      check($sformatf("R13 vec%0d done", i), done_o, 1);
    end

    // R2 load wins over start
    load_i = 1'b1; load_data_i = 16'h2222; start_i = 1'b1; op_i = 3'd0;
    @(negedge clk_i);
    load_i = 1'b0; start_i = 1'b0;
    check("R2 word", word_o, 16'h2222);
    check("R2 done", done_o, 0);

    // R3 config held without cfg_we_i
    load_i = 1'b1; load_data_i = 16'h000F;
    cfg_we_i = 1'b1; size_i = 2'd0; sel_i = 2'd0;
    @(negedge clk_i);
    load_i = 1'b0; cfg_we_i = 1'b0;
    size_i = 2'd2; sel_i = 2'd3;
    start_i = 1'b1; op_i = 3'd0;
    @(negedge clk_i);
    check("R3 hold word a", word_o, 16'h0000);
    check("R3 hold flags a", flags_o, 2'b01);
    @(negedge clk_i);
    start_i = 1'b0;
    check("R3 hold word b", word_o, 16'h000F);
    check("R3 hold cnt b", cnt_o, 4);
    @(negedge clk_i);
    // R13 idle cycle
    check("R13 idle done", done_o, 0);
    check("R13 idle word", word_o, 16'h000F);

    // R11 combine
    opa_i = 4'b1110; opb_i = 2'b01; start_i = 1'b1; op_i = 3'd5;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R11 hdr", hdr_o, 4'b1001);
    check("R11 word", word_o, 16'h000F);
    check("R11 cnt", cnt_o, 4);
    check("R11 flags", flags_o, 2'b01);

    // R12 split
    opa_i = 4'b0110; start_i = 1'b1; op_i = 3'd6;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R12 split a", split_a_o, 2'b01);
    check("R12 split b", split_b_o, 2'b10);
    check("R12 hdr kept", hdr_o, 4'b1001);

    // R12 op 7 has no effect apart from done
    opa_i = 4'b1011; opb_i = 2'b11; start_i = 1'b1; op_i = 3'd7;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R12 rsvd done", done_o, 1);
    check("R12 rsvd outs", {word_o, cnt_o, flags_o, hdr_o, split_a_o, split_b_o},
          {16'h000F, 5'd4, 2'b01, 4'b1001, 2'b01, 2'b10});

    summary();
    $finish;
  end
endmodule